// File: doc/BRIEF.md
# Instruction Byte Window Queue

This block sits between a fetch port that returns 32-bit words and an instruction decoder that reads a variable number of bytes per cycle. It holds up to seven bytes in a shift register. The oldest byte that has not been consumed is always at window position 0. In each cycle the decoder reports how many bytes it used, from zero to four. The queue drops those bytes from the front and moves the rest down.

A fetch word is taken only as a whole four-byte unit, and only when four slots are free once this cycle's consumption is accounted for. Its bytes go directly after the bytes that remain. A flush input empties the queue in one cycle, for example when the decoder takes a jump. A fetch word offered in the same cycle as a flush is discarded. The window contents and the valid-byte count come straight from registers, so the decoder sees a clean, registered view at each clock edge.

Top module: `insn_byte_queue`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the valid count `win_count` is 0.
- R2: After a cycle with no flush in which `take` bytes were consumed, the byte that was at window position `take` is at position 0. Window position k is `win_data[8k+7:8k]`.
- R3: A word accepted into an empty queue fills positions 0 to 3 in little-endian order, so `fetch_data[7:0]` lands at position 0.
- R4: `fetch_ready` is high exactly when `flush` is low and `win_count - take` is at most 3. The value of `fetch_valid` does not affect it.
- R5: A word offered while `fetch_ready` is low is not stored. On the next cycle the count is `win_count - take` and the remaining bytes are unchanged.
- R6: When bytes are consumed and a word is accepted in the same cycle, removal happens first. The new bytes then start at position `win_count - take`.
- R7: Without a flush, the next count is `win_count - take`, plus 4 if a word was accepted. The count never exceeds 7.
- R8: A flush sets the count to 0 on the next cycle, holds `fetch_ready` low, and discards any word offered in that cycle.
- R9: `take` must never exceed `win_count`.
- R10: A `take` of 0 with no accepted word leaves both the count and the valid bytes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empties the queue and refuses the current fetch word |
| fetch_valid | input | 1 | A fetch word is offered |
| fetch_data | input | 32 | Fetch word; byte 0 is the lowest in address order |
| fetch_ready | output | 1 | The offered word is accepted at this clock edge |
| take | input | 3 | Number of bytes the decoder consumes this cycle (0 to 4) |
| win_data | output | 56 | Window bytes; position k is bits 8k+7 down to 8k |
| win_count | output | 3 | Number of valid bytes in the window |

## Verification
Consumption and append often fall in the same cycle. The harder case is when `take` decides whether the word fits at all. This happens at counts of 4 through 7, where a larger `take` can change a refusal into an acceptance. The stimulus table walks the count through these values while pairing every `take` with an offered word. A byte-level queue model in the bench predicts the acceptance, the new count and each valid byte. A second collision, flush against an offered word, is provoked with a full queue and a nonzero `take`. It is judged by an empty count and a low `fetch_ready` in that same cycle.

// File: rtl/ibq_pkg.sv
package ibq_pkg;

  // Bytes left after the decoder removes its share this cycle.
  function automatic int kept_after(input int count, input int take);
    return count - take;
  endfunction

  // True when a whole word fits behind the kept bytes.
  function automatic bit word_fits(input int kept, input int depth, input int word_bytes);
    return (depth - kept) >= word_bytes;
  endfunction

  // Count after one cycle, without flush.
  function automatic int next_count(input int kept, input bit accepted, input int word_bytes);
    return kept + (accepted ? word_bytes : 0);
  endfunction

endpackage

// File: rtl/ibq_shift.sv
module ibq_shift #(
  parameter int DEPTH    = 7,
  parameter int MAX_TAKE = 4,
  localparam int TW      = $clog2(MAX_TAKE + 1)
) (
  input  logic [DEPTH*8-1:0] bytes_in,
  input  logic [TW-1:0]      take,
  output logic [DEPTH*8-1:0] bytes_out
);

  // Each output position picks the input byte that lies `take` slots above it.
  for (genvar i = 0; i < DEPTH; i++) begin : g_pos
    always_comb begin
      bytes_out[8*i +: 8] = 8'h00;
      for (int k = 0; k <= MAX_TAKE; k++) begin
        if (take == TW'(k) && (i + k) < DEPTH) begin
          bytes_out[8*i +: 8] = bytes_in[8*(i+k) +: 8];
        end
      end
    end
  end

endmodule

// File: rtl/ibq_append.sv
module ibq_append #(
  parameter int DEPTH      = 7,
  parameter int WORD_BYTES = 4,
  localparam int CW        = $clog2(DEPTH + 1)
) (
  input  logic [DEPTH*8-1:0]      bytes_in,
  input  logic [CW-1:0]           kept,
  input  logic                    enable,
  input  logic [WORD_BYTES*8-1:0] word,
  output logic [DEPTH*8-1:0]      bytes_out
);

  // Word byte o goes to position kept+o; other positions keep the shifted byte.
  for (genvar i = 0; i < DEPTH; i++) begin : g_pos
    always_comb begin
      bytes_out[8*i +: 8] = bytes_in[8*i +: 8];
      for (int o = 0; o < WORD_BYTES; o++) begin
        if (enable && (int'(kept) + o) == i) begin
          bytes_out[8*i +: 8] = word[8*o +: 8];
        end
      end
    end
  end

endmodule

// File: rtl/ibq_ctrl.sv
module ibq_ctrl #(
  parameter int DEPTH      = 7,
  parameter int WORD_BYTES = 4,
  parameter int MAX_TAKE   = 4,
  localparam int CW        = $clog2(DEPTH + 1),
  localparam int TW        = $clog2(MAX_TAKE + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          fetch_valid,
  input  logic [TW-1:0] take,
  output logic          fetch_ready,
  output logic          accept,
  output logic [CW-1:0] kept,
  output logic [CW-1:0] count
);

  logic          room;
  logic [CW-1:0] count_d;

  always_comb begin
    kept        = CW'(ibq_pkg::kept_after(int'(count), int'(take)));
    room        = ibq_pkg::word_fits(int'(kept), DEPTH, WORD_BYTES);
    fetch_ready = !flush && room;
    accept      = fetch_valid && fetch_ready;
    count_d     = flush ? '0 : CW'(ibq_pkg::next_count(int'(kept), accept, WORD_BYTES));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else        count <= count_d;
  end

endmodule

// File: rtl/insn_byte_queue.sv
module insn_byte_queue #(
  parameter int DEPTH      = 7,
  parameter int WORD_BYTES = 4,
  parameter int MAX_TAKE   = 4,
  localparam int CW        = $clog2(DEPTH + 1),
  localparam int TW        = $clog2(MAX_TAKE + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flush,
  input  logic                    fetch_valid,
  input  logic [WORD_BYTES*8-1:0] fetch_data,
  output logic                    fetch_ready,
  input  logic [TW-1:0]           take,
  output logic [DEPTH*8-1:0]      win_data,
  output logic [CW-1:0]           win_count
);

  // Named internal events, brought out for the checker.
  logic                 accept_evt;
  logic [CW-1:0]        kept_cnt;
  logic [DEPTH*8-1:0]   shifted;
  logic [DEPTH*8-1:0]   merged;
  logic [DEPTH*8-1:0]   store_q;

  ibq_ctrl #(.DEPTH(DEPTH), .WORD_BYTES(WORD_BYTES), .MAX_TAKE(MAX_TAKE)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush       (flush),
    .fetch_valid (fetch_valid),
    .take        (take),
    .fetch_ready (fetch_ready),
    .accept      (accept_evt),
    .kept        (kept_cnt),
    .count       (win_count)
  );

  ibq_shift #(.DEPTH(DEPTH), .MAX_TAKE(MAX_TAKE)) u_shift (
    .bytes_in  (store_q),
    .take      (take),
    .bytes_out (shifted)
  );

  ibq_append #(.DEPTH(DEPTH), .WORD_BYTES(WORD_BYTES)) u_append (
    .bytes_in  (shifted),
    .kept      (kept_cnt),
    .enable    (accept_evt),
    .word      (fetch_data),
    .bytes_out (merged)
  );

  // Bytes above the count are don't-care; storage is always loaded.
  always_ff @(posedge clk) begin
    if (!rst_n) store_q <= '0;
    else        store_q <= merged;
  end

  assign win_data = store_q;

endmodule

// File: rtl/ibq_checker.sv
module ibq_checker #(
  parameter int DEPTH      = 7,
  parameter int WORD_BYTES = 4,
  parameter int MAX_TAKE   = 4,
  localparam int CW        = $clog2(DEPTH + 1),
  localparam int TW        = $clog2(MAX_TAKE + 1)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    flush,
  input logic                    fetch_valid,
  input logic [WORD_BYTES*8-1:0] fetch_data,
  input logic                    fetch_ready,
  input logic [TW-1:0]           take,
  input logic [DEPTH*8-1:0]      win_data,
  input logic [CW-1:0]           win_count,
  input logic                    accept_evt,
  input logic [CW-1:0]           kept_cnt
);

  function automatic logic [7:0] pick(input logic [DEPTH*8-1:0] v, input int k);
    return v[8*k +: 8];
  endfunction

  assert_take_le_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    int'(take) <= int'(win_count));

  assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    int'(win_count) <= DEPTH);

  assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |=> int'(win_count) == $past(int'(win_count)) - $past(int'(take))
                + ($past(accept_evt) ? WORD_BYTES : 0));

  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> win_count == '0);

  assert_ready_room_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_ready |-> !flush && (int'(win_count) - int'(take)) <= DEPTH - WORD_BYTES);

  assert_refused_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !fetch_ready && !flush) |=>
      int'(win_count) == $past(int'(win_count)) - $past(int'(take)));

  assert_head_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && take < win_count) |=> win_data[7:0] == $past(pick(win_data, int'(take))));

  assert_append_place_R6: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> pick(win_data, int'($past(kept_cnt))) == $past(fetch_data[7:0]));

endmodule

bind insn_byte_queue ibq_checker #(
  .DEPTH(DEPTH), .WORD_BYTES(WORD_BYTES), .MAX_TAKE(MAX_TAKE)
) u_ibq_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .flush       (flush),
  .fetch_valid (fetch_valid),
  .fetch_data  (fetch_data),
  .fetch_ready (fetch_ready),
  .take        (take),
  .win_data    (win_data),
  .win_count   (win_count),
  .accept_evt  (accept_evt),
  .kept_cnt    (kept_cnt)
);

// File: tb/test_insn_byte_queue.sv
`timescale 1ns/1ps
module test_insn_byte_queue;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        fetch_valid = 1'b0;
  logic [31:0] fetch_data = '0;
  logic        fetch_ready;
  logic [2:0]  take = '0;
  logic [55:0] win_data;
  logic [2:0]  win_count;

  int applied = 0;
  int miscompares = 0;
  bit done = 1'b0;

  // Reference queue: independent byte list.
  logic [7:0] mq [0:6];
  int         mc = 0;

  always #2.5 clk = ~clk;

  insn_byte_queue i_insn_byte_queue (
    .clk(clk), .rst_n(rst_n), .flush(flush), .fetch_valid(fetch_valid),
    .fetch_data(fetch_data), .fetch_ready(fetch_ready), .take(take),
    .win_data(win_data), .win_count(win_count)
  );

  // {flush, fetch_valid, take[2:0], data[31:0]}
  localparam logic [36:0] VEC [0:19] = '{
    {1'b0, 1'b1, 3'd0, 32'h03020100},  // empty -> 4 (R3)
    {1'b0, 1'b1, 3'd0, 32'h17161514},  // rem 4 refused (R5)
    {1'b0, 1'b1, 3'd1, 32'h0B0A0908},  // rem 3 accepted -> 7 (R6)
    {1'b0, 1'b1, 3'd2, 32'h27262524},  // rem 5 refused
    {1'b0, 1'b1, 3'd3, 32'h33323130},  // rem 2 accepted -> 6
    {1'b0, 1'b1, 3'd4, 32'h43424140},  // rem 2 accepted -> 6
    {1'b0, 1'b0, 3'd2, 32'h00000000},  // consume only -> 4
    {1'b0, 1'b1, 3'd4, 32'h53525150},  // rem 0 accepted -> 4
    {1'b0, 1'b0, 3'd0, 32'hDEADBEEF},  // hold (R10)
    {1'b1, 1'b1, 3'd1, 32'h63626160},  // flush drops word (R8)
    {1'b0, 1'b1, 3'd0, 32'h73727170},  // -> 4
    {1'b0, 1'b1, 3'd1, 32'h83828180},  // -> 7
    {1'b0, 1'b1, 3'd4, 32'h93929190},  // rem 3 accepted -> 7
    {1'b0, 1'b1, 3'd0, 32'hA3A2A1A0},  // full refused
    {1'b0, 1'b0, 3'd0, 32'h00000000},  // hold full (R10)
    {1'b0, 1'b0, 3'd4, 32'h00000000},  // -> 3
    {1'b0, 1'b1, 3'd3, 32'hB3B2B1B0},  // -> 4
    {1'b0, 1'b1, 3'd3, 32'hC3C2C1C0},  // rem 1 -> 5
    {1'b0, 1'b0, 3'd1, 32'h00000000},  // -> 4
    {1'b1, 1'b0, 3'd0, 32'h00000000}   // flush, nothing offered
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    applied++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Called at a negative edge; returns at the next negative edge.
  task automatic step(input bit fl, input bit fv, input int tk_req, input logic [31:0] d);
    int  tk;
    bit  rdy;
    int  rem;
    bit  bad;
    int  first_bad;
    tk = (tk_req > mc) ? mc : tk_req;   // R9: never take more than is valid
    flush = fl; fetch_valid = fv; take = 3'(tk); fetch_data = d;
    #1;
    rem = mc - tk;
    rdy = !fl && rem <= 3;
    check(fetch_ready == rdy, fl ? "R8" : "R4", "fetch_ready", int'(fetch_ready), int'(rdy));
    @(posedge clk);
    if (fl) mc = 0;
    else begin
      for (int k = 0; k < 7; k++) mq[k] = (k + tk < 7) ? mq[k+tk] : 8'h00;
      mc = rem;
      if (fv && rdy) begin
        for (int o = 0; o < 4; o++) mq[mc+o] = d[8*o +: 8];
        mc = mc + 4;
      end
    end
    @(negedge clk);
    check(int'(win_count) == mc, fl ? "R8" : "R7", "win_count", int'(win_count), mc);
    bad = 1'b0; first_bad = 0;
    for (int k = 0; k < mc; k++) begin
      if (win_data[8*k +: 8] !== mq[k] && !bad) begin bad = 1'b1; first_bad = k; end
    end
    check(!bad, "R2/R3/R5/R6/R10", "window byte",
          int'(win_data[8*first_bad +: 8]), int'(mq[first_bad]));
  endtask

  task automatic do_reset();
    rst_n = 1'b0; flush = 1'b0; fetch_valid = 1'b0; take = '0;
    repeat (3) @(negedge clk);
    check(win_count == 3'd0, "R1", "count in reset", int'(win_count), 0);
    rst_n = 1'b1;
    mc = 0;
    for (int k = 0; k < 7; k++) mq[k] = 8'h00;
    @(negedge clk);
    check(win_count == 3'd0, "R1", "count after reset", int'(win_count), 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end

  initial begin
    do_reset();

    for (int v = 0; v < 20; v++) begin
      step(VEC[v][36], VEC[v][35], int'(VEC[v][34:32]), VEC[v][31:0]);
    end

    // Directed: fill to 7, then flush with a word offered and a nonzero take (R8).
    step(1'b0, 1'b1, 0, 32'hE3E2E1E0);
    step(1'b0, 1'b1, 1, 32'hF3F2F1F0);
    step(1'b1, 1'b1, 3, 32'h11223344);
    // Refill: first word after flush lands at 0..3 (R3).
    step(1'b0, 1'b1, 0, 32'h5A5B5C5D);
    // Consume one byte at a time down to empty (R2).
    for (int n = 0; n < 4; n++) step(1'b0, 1'b0, 1, 32'h0);
    // Word offered with valid low is ignored (R4 ready still high).
    step(1'b0, 1'b0, 0, 32'hFFFFFFFF);
    // Reset in mid-run clears the count (R1).
    step(1'b0, 1'b1, 0, 32'h66554433);
    do_reset();
    step(1'b0, 1'b1, 0, 32'h0D0C0B0A);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

endmodule